// File: doc/BRIEF.md
# Interrupt Steering Aggregator

The block gathers a parameterised number of level-sensitive interrupt inputs (a multiple of 32, at most 512) and folds them onto a few output lines, one line per group of 64 consecutive inputs. Software works through a small memory-mapped register port with 32-bit data. It enables inputs through per-word mask registers. It forces inputs pending through per-word set registers. It reads the masked pending state through per-word status registers.

A channel-select register picks which copy of the merged lines is driven. Each selected channel gets its own copy of the group outputs. A per-group disable register and a per-group state register let software silence a group and observe it. The 32-bit words are numbered in reverse: word 0 holds the highest-numbered inputs.

Top module: `irq_steer`

## Requirements
- R1: After reset, every register reads zero and every bit of `irq_out` is low. Reset clears all inputs to masked, no channel selected, no set bits and no disable bits.
- R2: With R = NUM_IRQ/32, input n sits at bit n mod 32 of word R-1-n/32. The byte offsets are as follows: channel select at 0x0; mask word k at 4+4k; set word k at 4R+4+4k; status word k at 8R+4+4k; group disable at 12R+4; group state at 12R+8.
- R3: Status bit = (input level OR set bit) AND mask bit, where a mask bit of 1 enables the input. A read of a status word shows the inputs as they are at the clock edge that captures the read.
- R4: Writes to status words change no register.
- R5: A set bit of 1 keeps its input pending until software writes it back to 0, whatever the input level.
- R6: Group i covers inputs 64i..64i+63, clipped to NUM_IRQ. The group is asserted one clock after any of its status bits is 1, and it drops one clock after none is.
- R7: `irq_out[c*NUM_OUT+i]` equals group i AND bit c of the channel-select register. Several select bits may be set at once.
- R8: Group-disable bit i at 1 holds group i low one clock later. Group-state bit i reads the asserted state of group i after the disable is applied.
- R9: A read of an unmapped or non-word-aligned offset returns zero. A write to such an offset changes nothing.
- R10: `bus_rdata` is loaded at the clock edge of a read cycle and holds its value through write and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_en | input | 1 | register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| irq_in | input | NUM_IRQ | level interrupt inputs |
| irq_out | output | NUM_CHAN*ceil(NUM_IRQ/64) | group outputs per channel |

## Verification
The bench builds the block with NUM_IRQ=96 and NUM_CHAN=3. This gives an odd word count of three, so the reversed word order and the register offsets can be told apart from a linear layout. It also makes the second group only 32 inputs wide, which exercises the clipped last group. Three channels let the bench drive single and multiple channel selections and confirm that each lands on its own slice of `irq_out`.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int WORD_W  = 32;
    localparam int GROUP_W = 64;
    localparam int IDX_W   = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CHAN,
        RG_MASK,
        RG_SET,
        RG_STAT,
        RG_GDIS,
        RG_GSTATE
    } region_e;

    typedef struct packed {
        region_e          region;
        logic [IDX_W-1:0] word;
    } decode_t;

    typedef struct packed {
        logic              en;
        logic              wr;
        decode_t           dec;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    // Map a byte offset onto a register region and a word index.
    function automatic decode_t decode_addr(input logic [31:0] byte_addr,
                                            input int nwords);
        decode_t d;
        int      idx;
        d.region = RG_NONE;
        d.word   = '0;
        if (byte_addr[1:0] == 2'b00) begin
            idx = int'(byte_addr[31:2]);
            if (idx == 0) begin
                d.region = RG_CHAN;
            end else if (idx <= nwords) begin
                d.region = RG_MASK;
                d.word   = IDX_W'(idx - 1);
            end else if (idx <= 2 * nwords) begin
                d.region = RG_SET;
                d.word   = IDX_W'(idx - 1 - nwords);
            end else if (idx <= 3 * nwords) begin
                d.region = RG_STAT;
                d.word   = IDX_W'(idx - 1 - 2 * nwords);
            end else if (idx == 3 * nwords + 1) begin
                d.region = RG_GDIS;
            end else if (idx == 3 * nwords + 2) begin
                d.region = RG_GSTATE;
            end
        end
        return d;
    endfunction

    // Word that holds input n (words run in reverse input order).
    function automatic int word_of_input(input int n, input int nwords);
        return nwords - 1 - n / WORD_W;
    endfunction

endpackage

// File: rtl/irqs_regfile.sv
module irqs_regfile
    import irqs_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int NUM_CHAN  = 2,
    parameter int NUM_OUT   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  bus_req_t                          req,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  status_words,
    input  logic [NUM_OUT-1:0]                grp_state,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  mask_q,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  set_q,
    output logic [NUM_CHAN-1:0]               chan_q,
    output logic [NUM_OUT-1:0]                gdis_q,
    output logic [WORD_W-1:0]                 rdata
);

    logic              wr_cycle;
    logic              rd_cycle;
    logic [WORD_W-1:0] rd_next;

    assign wr_cycle = req.en && req.wr;
    assign rd_cycle = req.en && !req.wr;

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] mask_r;
        logic [WORD_W-1:0] set_r;
        logic              hit;

        assign hit = wr_cycle && (req.dec.word == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_r <= '0;
                set_r  <= '0;
            end else if (hit) begin
                if (req.dec.region == RG_MASK) mask_r <= req.wdata;
                if (req.dec.region == RG_SET)  set_r  <= req.wdata;
            end
        end

        assign mask_q[k] = mask_r;
        assign set_q[k]  = set_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            gdis_q <= '0;
        end else if (wr_cycle) begin
            if (req.dec.region == RG_CHAN) chan_q <= req.wdata[NUM_CHAN-1:0];
            if (req.dec.region == RG_GDIS) gdis_q <= req.wdata[NUM_OUT-1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        case (req.dec.region)
            RG_CHAN:   rd_next = WORD_W'(chan_q);
            RG_GDIS:   rd_next = WORD_W'(gdis_q);
            RG_GSTATE: rd_next = WORD_W'(grp_state);
            RG_MASK, RG_SET, RG_STAT: begin
                for (int k = 0; k < NUM_WORDS; k++) begin
                    if (req.dec.word == IDX_W'(k)) begin
                        if (req.dec.region == RG_MASK)     rd_next = mask_q[k];
                        else if (req.dec.region == RG_SET) rd_next = set_q[k];
                        else                               rd_next = status_words[k];
                    end
                end
            end
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata <= '0;
        else if (rd_cycle) rdata <= rd_next;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_q == '0 && gdis_q == '0 && mask_q == '0 && set_q == '0));

    // R4
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cycle && req.dec.region == RG_STAT) |=>
            ($stable(mask_q) && $stable(set_q) && $stable(chan_q) && $stable(gdis_q)));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cycle && req.dec.region == RG_NONE) |=> (rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_cycle |=> $stable(rdata));

endmodule

// File: rtl/irqs_pending.sv
module irqs_pending
    import irqs_pkg::*;
#(
    parameter int NUM_IRQ   = 128,
    parameter int NUM_WORDS = NUM_IRQ / WORD_W
) (
    input  logic [NUM_IRQ-1:0]                irq_in,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  mask_q,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  set_q,
    output logic [NUM_IRQ-1:0]                pend,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  status_words
);

    // Pending vector kept in input order.
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_in
        localparam int W = word_of_input(n, NUM_WORDS);
        localparam int B = n % WORD_W;
        assign pend[n] = (irq_in[n] | set_q[W][B]) & mask_q[W][B];
    end

    // Status words are the same bits seen in reversed word order.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam int BASE = (NUM_WORDS - 1 - k) * WORD_W;
        assign status_words[k] = pend[BASE +: WORD_W];
    end

endmodule

// File: rtl/irqs_merge.sv
module irqs_merge
    import irqs_pkg::*;
#(
    parameter int NUM_IRQ  = 128,
    parameter int NUM_OUT  = 2,
    parameter int NUM_CHAN = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_IRQ-1:0]           pend,
    input  logic [NUM_OUT-1:0]           gdis_q,
    input  logic [NUM_CHAN-1:0]          chan_q,
    output logic [NUM_OUT-1:0]           grp_q,
    output logic [NUM_CHAN*NUM_OUT-1:0]  irq_out
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_grp
        localparam int LO = i * GROUP_W;
        localparam int HI = ((LO + GROUP_W) < NUM_IRQ ? (LO + GROUP_W) : NUM_IRQ) - 1;
        logic any_pend;

        assign any_pend = |pend[HI:LO];

        always_ff @(posedge clk) begin
            if (rst) grp_q[i] <= 1'b0;
            else     grp_q[i] <= any_pend & ~gdis_q[i];
        end

        // R8
        gdis_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
            $past(gdis_q[i]) |-> !grp_q[i]);

        // R6
        group_follows_chk: assert property (@(posedge clk) disable iff (rst)
            $past(any_pend && !gdis_q[i]) |-> grp_q[i]);
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
            assign irq_out[c*NUM_OUT + i] = grp_q[i] & chan_q[c];
        end
    end

endmodule

// File: rtl/irq_steer.sv
module irq_steer
    import irqs_pkg::*;
#(
    parameter int NUM_IRQ  = 128,
    parameter int NUM_CHAN = 2,
    parameter int ADDR_W   = 10
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       bus_en,
    input  logic                                       bus_wr,
    input  logic [ADDR_W-1:0]                          bus_addr,
    input  logic [31:0]                                bus_wdata,
    output logic [31:0]                                bus_rdata,
    input  logic [NUM_IRQ-1:0]                         irq_in,
    output logic [NUM_CHAN*((NUM_IRQ+63)/64)-1:0]      irq_out
);

    localparam int NUM_WORDS = NUM_IRQ / WORD_W;
    localparam int NUM_OUT   = (NUM_IRQ + GROUP_W - 1) / GROUP_W;

    bus_req_t                         req;
    logic [NUM_WORDS-1:0][WORD_W-1:0] mask_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] set_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] status_words;
    logic [NUM_CHAN-1:0]              chan_q;
    logic [NUM_OUT-1:0]               gdis_q;
    logic [NUM_OUT-1:0]               grp_q;
    logic [NUM_IRQ-1:0]               pend;

    always_comb begin
        req.en    = bus_en;
        req.wr    = bus_wr;
        req.wdata = bus_wdata;
        req.dec   = decode_addr(32'(bus_addr), NUM_WORDS);
    end

    irqs_regfile #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_CHAN  (NUM_CHAN),
        .NUM_OUT   (NUM_OUT)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .status_words (status_words),
        .grp_state    (grp_q),
        .mask_q       (mask_q),
        .set_q        (set_q),
        .chan_q       (chan_q),
        .gdis_q       (gdis_q),
        .rdata        (bus_rdata)
    );

    irqs_pending #(
        .NUM_IRQ   (NUM_IRQ),
        .NUM_WORDS (NUM_WORDS)
    ) u_pend (
        .irq_in       (irq_in),
        .mask_q       (mask_q),
        .set_q        (set_q),
        .pend         (pend),
        .status_words (status_words)
    );

    irqs_merge #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_OUT  (NUM_OUT),
        .NUM_CHAN (NUM_CHAN)
    ) u_merge (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .gdis_q  (gdis_q),
        .chan_q  (chan_q),
        .grp_q   (grp_q),
        .irq_out (irq_out)
    );

    // R7
    channel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_out) |-> (|chan_q));

endmodule

// File: tb/irq_steer_bench.sv
module irq_steer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ  = 96;
    localparam int NCHAN = 3;
    localparam int AW    = 10;
    localparam int OW    = NCHAN * 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_en = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NIRQ-1:0] irq_in = '0;
    logic [OW-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] expq[$];
    string       tagq[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_steer #(.NUM_IRQ(NIRQ), .NUM_CHAN(NCHAN), .ADDR_W(AW)) u_irq_steer (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    // Read-response monitor: scoreboard side.
    always @(posedge clk) rd_seen <= bus_en && !bus_wr && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string       t;
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL read with no expectation: actual %h expected none", bus_rdata);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        tick();
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        expq.push_back(e);
        tagq.push_back(tag);
        tick();
        bus_en = 1'b0;
    endtask

    task automatic chk_out(input logic [OW-1:0] e, input string tag);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, irq_out, e);
        end
    endtask

    task automatic chk_rdata(input logic [31:0] e, input string tag);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, bus_rdata, e);
        end
    endtask

    // Offsets for R = 3 words: mask 4/8/12, set 16/20/24, status 28/32/36,
    // group disable 40, group state 44.
    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        chk_out('0, "R1 outputs after reset");
        rd(0,  0, "R1 channel select");
        rd(4,  0, "R1 mask word 0");
        rd(44, 0, "R1 group state");

        irq_in[0] = 1'b1;
        tick();
        rd(36, 0, "R3 masked input");
        chk_out('0, "R3 masked output");

        wr(12, 32'h1);
        rd(36, 32'h1, "R2 R3 input 0 in last word");
        rd(28, 32'h0, "R2 word 0 unaffected");
        tick();
        rd(44, 32'h1, "R8 group state shows group 0");
        chk_out('0, "R7 no channel selected");

        wr(0, 32'b010);
        tick();
        chk_out(6'b000100, "R7 channel 1 group 0");

        irq_in[0] = 1'b0;
        tick();
        chk_out('0, "R6 level drop");

        irq_in[95] = 1'b1;
        wr(4, 32'h8000_0000);
        tick();
        chk_out(6'b001000, "R2 R6 input 95 in group 1");
        rd(28, 32'h8000_0000, "R2 input 95 at word 0 bit 31");

        wr(8, 32'h20);
        wr(20, 32'h20);
        tick();
        chk_out(6'b001100, "R5 set forces input 37");
        rd(32, 32'h20, "R5 R3 status from set bit");
        repeat (3) tick();
        chk_out(6'b001100, "R5 set held");
        wr(20, 32'h0);
        tick();
        chk_out(6'b001000, "R5 set cleared");

        wr(36, 32'hFFFF_FFFF);
        rd(12, 32'h1, "R4 mask kept");
        rd(24, 32'h0, "R4 set kept");
        rd(36, 32'h0, "R4 status unchanged");
        tick();
        chk_out(6'b001000, "R4 outputs unchanged");

        wr(40, 32'h2);
        tick();
        chk_out('0, "R8 group 1 disabled");
        rd(44, 32'h0, "R8 group state after disable");
        rd(40, 32'h2, "R8 disable readback");
        wr(40, 32'h0);
        tick();
        chk_out(6'b001000, "R8 disable released");

        wr(48, 32'hFFFF_FFFF);
        wr(1, 32'h0);
        wr(12'h3FC, 32'hFFFF_FFFF);
        rd(48, 0, "R9 unmapped read");
        rd(12'h3FC, 0, "R9 far unmapped read");
        rd(1, 0, "R9 unaligned read");
        rd(0, 32'b010, "R9 channel select kept");
        tick();
        chk_out(6'b001000, "R9 outputs unchanged");

        wr(0, 32'b101);
        tick();
        chk_out(6'b100010, "R7 channels 0 and 2");

        wr(4, 32'h8000_0001);
        irq_in[95] = 1'b0;
        irq_in[64] = 1'b1;
        tick();
        chk_out(6'b100010, "R6 clipped group input 64");
        irq_in[64] = 1'b0;
        tick();
        chk_out('0, "R6 clipped group drops");

        rd(4, 32'h8000_0001, "R10 mask readback");
        tick();
        tick();
        chk_rdata(32'h8000_0001, "R10 rdata held idle");
        wr(8, 32'h0);
        chk_rdata(32'h8000_0001, "R10 rdata held over write");

        irq_in[0] = 1'b1;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        tick();
        chk_out('0, "R1 outputs after second reset");
        rd(0,  0, "R1 channel select cleared");
        rd(12, 0, "R1 mask cleared");
        rd(36, 0, "R1 status masked");
        tick();
        tick();

        if (expq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", expq.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule